// File: doc/BRIEF.md
# Floating-Point Operation Sequencer

This block is the control state machine of a floating-point unit that is built from several separate functional units: add/subtract, multiply, divide, square root, integer/float conversion and a rounding-function unit (ceiling, floor, fraction). A shared normaliser follows all of them. The sequencer reads a 5-bit operation code and launches the matching functional unit with a one-cycle start pulse. It waits for that unit's completion flag, then launches the normaliser and waits for it. When the normaliser finishes, the sequencer pulses an overall completion flag and goes back to idle.

Alongside the start pulses, the sequencer drives three mode controls: the add-versus-subtract choice, the conversion direction and the 2-bit rounding-function choice. They are captured when an operation is launched and stay constant until the next launch. Operation code 00000 is a no-operation that keeps the sequencer idle, so the host returns the code to 00000 between operations. An operation code that maps to no operation is rejected. The rejection is a completion pulse with no unit started.

Top module: `fpu_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every start output, `norm_start` and `op_done` are 0, and `add_sub_sel`, `conv_to_int` and `round_sel` are 0.
- R2: While idle with `op_code` = 00000, no start output and no `op_done` is raised.
- R3: In idle, a valid code sampled at a clock edge raises exactly one unit start in the following cycle, for exactly one cycle. The codes are 00001 add and 00010 subtract (`add_start`), 00011 multiply (`mul_start`), 00100 divide (`div_start`), 00101 square root (`sqrt_start`), 00110 ceiling, 00111 floor and 01000 fraction (`round_start`), 01001 float-to-integer and 01010 integer-to-float (`conv_start`).
- R4: The mode controls take their values from the code at launch and hold them until the next launch. `add_sub_sel` is 1 only for subtract. `conv_to_int` is 1 only for float-to-integer. `round_sel` is 00 for ceiling, 01 for floor, 10 for fraction and 00 otherwise.
- R5: While the sequencer waits on a unit, completion flags from the other five units and `norm_done` have no effect.
- R6: The selected unit's completion flag, sampled at an edge, raises `norm_start` for exactly the following cycle.
- R7: `norm_done`, sampled at an edge while normalising, raises `op_done` for exactly the following cycle and returns the sequencer to idle. Unit completion flags have no effect while normalising.
- R8: In idle, a code from 01011 to 11111 raises `op_done` for one cycle in the following cycle and starts no unit and no normaliser.
- R9: Changes on `op_code` after launch, until the operation completes, start nothing and leave the mode controls unchanged.
- R10: At most one of the seven start outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| op_code | input | 5 | Operation code, sampled in idle |
| add_done | input | 1 | Add/subtract unit finished |
| mul_done | input | 1 | Multiplier finished |
| div_done | input | 1 | Divider finished |
| sqrt_done | input | 1 | Square-root unit finished |
| conv_done | input | 1 | Conversion unit finished |
| round_done | input | 1 | Rounding-function unit finished |
| norm_done | input | 1 | Normaliser finished |
| add_start | output | 1 | Start pulse to add/subtract unit |
| add_sub_sel | output | 1 | 1 = subtract, 0 = add |
| mul_start | output | 1 | Start pulse to multiplier |
| div_start | output | 1 | Start pulse to divider |
| sqrt_start | output | 1 | Start pulse to square-root unit |
| conv_start | output | 1 | Start pulse to conversion unit |
| conv_to_int | output | 1 | 1 = float to integer, 0 = integer to float |
| round_start | output | 1 | Start pulse to rounding-function unit |
| round_sel | output | 2 | 00 ceiling, 01 floor, 10 fraction |
| norm_start | output | 1 | Start pulse to normaliser |
| op_done | output | 1 | One-cycle pulse: operation complete or rejected |

## Verification
The assertions check the following on every cycle: the start outputs are mutually exclusive, each start, `norm_start` and `op_done` lasts only one cycle, a unit start appears only in the waiting phase, the mode controls stay still through an operation, and an undefined code gives a completion pulse with no start. The bench scenarios cover the rest. They map each of the ten operation codes to its unit and mode values, and they show that stray completion flags from other units and an opcode changed mid-operation have no effect. They also check the exact cycle in which each pulse appears after the flag that causes it.

// File: rtl/fpu_seq_pkg.sv
package fpu_seq_pkg;

  localparam int OP_W    = 5;
  localparam int N_UNITS = 6;
  localparam int RSEL_W  = 2;

  // unit slot order used for start and done vectors
  localparam int U_ADD   = 0;
  localparam int U_MUL   = 1;
  localparam int U_DIV   = 2;
  localparam int U_SQRT  = 3;
  localparam int U_CONV  = 4;
  localparam int U_ROUND = 5;

  localparam logic [OP_W-1:0] OPC_NOP   = 5'b00000;
  localparam logic [OP_W-1:0] OPC_ADD   = 5'b00001;
  localparam logic [OP_W-1:0] OPC_SUB   = 5'b00010;
  localparam logic [OP_W-1:0] OPC_MUL   = 5'b00011;
  localparam logic [OP_W-1:0] OPC_DIV   = 5'b00100;
  localparam logic [OP_W-1:0] OPC_SQRT  = 5'b00101;
  localparam logic [OP_W-1:0] OPC_CEIL  = 5'b00110;
  localparam logic [OP_W-1:0] OPC_FLOOR = 5'b00111;
  localparam logic [OP_W-1:0] OPC_FRAC  = 5'b01000;
  localparam logic [OP_W-1:0] OPC_F2I   = 5'b01001;
  localparam logic [OP_W-1:0] OPC_I2F   = 5'b01010;

  localparam logic [RSEL_W-1:0] RSEL_CEIL  = 2'b00;
  localparam logic [RSEL_W-1:0] RSEL_FLOOR = 2'b01;
  localparam logic [RSEL_W-1:0] RSEL_FRAC  = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_UNIT = 2'b01,
    ST_NORM = 2'b10
  } seq_state_t;

  typedef struct packed {
    logic                 is_nop;
    logic                 valid;
    logic [N_UNITS-1:0]   unit_sel;
    logic                 sub;
    logic                 to_int;
    logic [RSEL_W-1:0]    rsel;
  } op_info_t;

endpackage

// File: rtl/fpu_op_decode.sv
module fpu_op_decode
  import fpu_seq_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output op_info_t        info
);

  always_comb begin
    info          = '0;
    info.is_nop   = (op_code == OPC_NOP);
    info.valid    = 1'b1;
    case (op_code)
      OPC_NOP:   info.valid = 1'b0;
      OPC_ADD:   info.unit_sel[U_ADD] = 1'b1;
      OPC_SUB: begin
        info.unit_sel[U_ADD] = 1'b1;
        info.sub             = 1'b1;
      end
      OPC_MUL:   info.unit_sel[U_MUL]  = 1'b1;
      OPC_DIV:   info.unit_sel[U_DIV]  = 1'b1;
      OPC_SQRT:  info.unit_sel[U_SQRT] = 1'b1;
      OPC_CEIL: begin
        info.unit_sel[U_ROUND] = 1'b1;
        info.rsel              = RSEL_CEIL;
      end
      OPC_FLOOR: begin
        info.unit_sel[U_ROUND] = 1'b1;
        info.rsel              = RSEL_FLOOR;
      end
      OPC_FRAC: begin
        info.unit_sel[U_ROUND] = 1'b1;
        info.rsel              = RSEL_FRAC;
      end
      OPC_F2I: begin
        info.unit_sel[U_CONV] = 1'b1;
        info.to_int           = 1'b1;
      end
      OPC_I2F:   info.unit_sel[U_CONV] = 1'b1;
      default:   info.valid = 1'b0;
    endcase
  end

  // R3: a valid code selects exactly one unit
  always_comb begin
    if (info.valid) begin
      a_r3_one_unit: assert ($countones(info.unit_sel) == 1);
    end
  end

endmodule

// File: rtl/fpu_unit_handshake.sv
module fpu_unit_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_hit,
  input  logic armed,
  input  logic done_in,
  output logic start,
  output logic done_hit
);

  logic start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= launch_hit;
    end
  end

  assign start    = start_q;
  assign done_hit = armed & done_in;

  // R3: a start pulse lasts one cycle
  a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

endmodule

// File: rtl/fpu_seq_ctrl.sv
module fpu_seq_ctrl
  import fpu_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_code,
  input  logic              add_done,
  input  logic              mul_done,
  input  logic              div_done,
  input  logic              sqrt_done,
  input  logic              conv_done,
  input  logic              round_done,
  input  logic              norm_done,
  output logic              add_start,
  output logic              add_sub_sel,
  output logic              mul_start,
  output logic              div_start,
  output logic              sqrt_start,
  output logic              conv_start,
  output logic              conv_to_int,
  output logic              round_start,
  output logic [RSEL_W-1:0] round_sel,
  output logic              norm_start,
  output logic              op_done
);

  seq_state_t          state_q, state_d;
  op_info_t            info;
  logic [N_UNITS-1:0]  done_vec;
  logic [N_UNITS-1:0]  start_vec;
  logic [N_UNITS-1:0]  hit_vec;
  logic [N_UNITS-1:0]  sel_q;
  logic                sub_q, to_int_q;
  logic [RSEL_W-1:0]   rsel_q;
  logic                norm_start_q, done_q;
  logic                in_idle, launch, reject, any_hit, norm_fin;

  assign done_vec[U_ADD]   = add_done;
  assign done_vec[U_MUL]   = mul_done;
  assign done_vec[U_DIV]   = div_done;
  assign done_vec[U_SQRT]  = sqrt_done;
  assign done_vec[U_CONV]  = conv_done;
  assign done_vec[U_ROUND] = round_done;

  fpu_op_decode u_decode (
    .op_code (op_code),
    .info    (info)
  );

  assign in_idle  = (state_q == ST_IDLE);
  assign launch   = in_idle & info.valid;
  assign reject   = in_idle & ~info.valid & ~info.is_nop;
  assign norm_fin = (state_q == ST_NORM) & norm_done;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    fpu_unit_handshake u_hs (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_hit (launch & info.unit_sel[g]),
      .armed      ((state_q == ST_UNIT) & sel_q[g]),
      .done_in    (done_vec[g]),
      .start      (start_vec[g]),
      .done_hit   (hit_vec[g])
    );
  end

  assign any_hit = |hit_vec;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch)    state_d = ST_UNIT;
      ST_UNIT: if (any_hit)   state_d = ST_NORM;
      ST_NORM: if (norm_done) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  // state and pulse registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      norm_start_q <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      state_q      <= state_d;
      norm_start_q <= (state_q == ST_UNIT) & any_hit;
      done_q       <= norm_fin | reject;
    end
  end

  // operation context, enabled on launch only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      sub_q    <= 1'b0;
      to_int_q <= 1'b0;
      rsel_q   <= '0;
    end else if (launch) begin
      sel_q    <= info.unit_sel;
      sub_q    <= info.sub;
      to_int_q <= info.to_int;
      rsel_q   <= info.rsel;
    end
  end

  assign add_start   = start_vec[U_ADD];
  assign mul_start   = start_vec[U_MUL];
  assign div_start   = start_vec[U_DIV];
  assign sqrt_start  = start_vec[U_SQRT];
  assign conv_start  = start_vec[U_CONV];
  assign round_start = start_vec[U_ROUND];
  assign add_sub_sel = sub_q;
  assign conv_to_int = to_int_q;
  assign round_sel   = rsel_q;
  assign norm_start  = norm_start_q;
  assign op_done     = done_q;

  // R10: start outputs are mutually exclusive
  a_r10_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_vec, norm_start_q}));

  // R3: unit starts only appear in the waiting phase
  a_r3_start_in_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_vec) |-> (state_q == ST_UNIT));

  // R6: normaliser start is a single pulse in the normalising phase
  a_r6_norm_single: assert property (@(posedge clk) disable iff (!rst_n)
    norm_start_q |-> ((state_q == ST_NORM) && !(|start_vec)));
  a_r6_norm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    norm_start_q |=> !norm_start_q);

  // R7: completion is a single pulse seen in idle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (state_q == ST_IDLE));

  // R4 and R9: mode controls hold while an operation runs
  a_r4_modes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && $past(state_q != ST_IDLE))
      |-> $stable({add_sub_sel, conv_to_int, round_sel}));

  // R8: an undefined code gives completion and no start
  a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !info.valid && !info.is_nop)
      |=> (op_done && !(|start_vec) && !norm_start_q));

endmodule

// File: tb/fpu_seq_ctrl_test.sv
module fpu_seq_ctrl_test;

  logic       clk;
  logic       rst_n;
  logic [4:0] op_code;
  logic [5:0] done_drv;
  logic       norm_done;
  logic       add_start, add_sub_sel, mul_start, div_start, sqrt_start;
  logic       conv_start, conv_to_int, round_start, norm_start, op_done;
  logic [1:0] round_sel;
  logic [5:0] starts;

  int checks   = 0;
  int failures = 0;

  fpu_seq_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_code     (op_code),
    .add_done    (done_drv[0]),
    .mul_done    (done_drv[1]),
    .div_done    (done_drv[2]),
    .sqrt_done   (done_drv[3]),
    .conv_done   (done_drv[4]),
    .round_done  (done_drv[5]),
    .norm_done   (norm_done),
    .add_start   (add_start),
    .add_sub_sel (add_sub_sel),
    .mul_start   (mul_start),
    .div_start   (div_start),
    .sqrt_start  (sqrt_start),
    .conv_start  (conv_start),
    .conv_to_int (conv_to_int),
    .round_start (round_start),
    .round_sel   (round_sel),
    .norm_start  (norm_start),
    .op_done     (op_done)
  );

  assign starts = {round_start, conv_start, sqrt_start, div_start, mul_start, add_start};

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; op_code = 5'b0; done_drv = '0; norm_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "starts in reset", {25'b0, starts, norm_start}, 0);
    check("R1", "done/modes in reset", {28'b0, op_done, add_sub_sel, conv_to_int, |round_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "starts after release", {25'b0, starts, norm_start}, 0);
    check("R1", "done/modes after release", {27'b0, op_done, add_sub_sel, conv_to_int, round_sel}, 0);
  endtask

  task automatic test_nop();
    op_code = 5'b00000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2", "idle with no-operation", {25'b0, starts, op_done}, 0);
    end
  endtask

  task automatic run_op(input logic [4:0] op, input int idx,
                        input logic sub, input logic ti, input logic [1:0] rs);
    logic [5:0] exp_start;
    logic [4:0] other_op;
    exp_start = 6'(1 << idx);
    other_op  = (op == 5'b00100) ? 5'b00011 : 5'b00100;
    op_code = op;
    @(negedge clk);
    check("R3", "unit start", {26'b0, starts}, {26'b0, exp_start});
    check("R3", "no norm/done at launch", {30'b0, norm_start, op_done}, 0);
    check("R4", "modes at launch", {28'b0, add_sub_sel, conv_to_int, round_sel}, {28'b0, sub, ti, rs});
    op_code = other_op;
    @(negedge clk);
    check("R3", "start lasts one cycle", {26'b0, starts}, 0);
    done_drv  = ~exp_start;
    norm_done = 1'b1;
    @(negedge clk);
    done_drv  = '0;
    norm_done = 1'b0;
    check("R5", "foreign done ignored", {30'b0, norm_start, op_done}, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9", "opcode change ignored", {25'b0, starts, norm_start}, 0);
    end
    done_drv = exp_start;
    @(negedge clk);
    done_drv = '0;
    check("R6", "norm start after unit done", {31'b0, norm_start}, 1);
    check("R9", "modes unchanged", {28'b0, add_sub_sel, conv_to_int, round_sel}, {28'b0, sub, ti, rs});
    done_drv = 6'h3f;
    @(negedge clk);
    done_drv = '0;
    check("R6", "norm start lasts one cycle", {31'b0, norm_start}, 0);
    check("R7", "unit done ignored while normalising", {25'b0, starts, op_done}, 0);
    op_code   = 5'b00000;
    norm_done = 1'b1;
    @(negedge clk);
    norm_done = 1'b0;
    check("R7", "completion pulse", {31'b0, op_done}, 1);
    check("R4", "modes held to completion", {28'b0, add_sub_sel, conv_to_int, round_sel}, {28'b0, sub, ti, rs});
    @(negedge clk);
    check("R7", "completion lasts one cycle", {31'b0, op_done}, 0);
    check("R2", "back in idle, nothing started", {25'b0, starts, norm_start}, 0);
  endtask

  task automatic test_reject(input logic [4:0] op);
    op_code = op;
    @(negedge clk);
    op_code = 5'b00000;
    check("R8", "rejected code completes", {31'b0, op_done}, 1);
    check("R8", "rejected code starts nothing", {25'b0, starts, norm_start}, 0);
    @(negedge clk);
    check("R8", "reject pulse one cycle", {25'b0, starts, op_done}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_nop();
    run_op(5'b00001, 0, 1'b0, 1'b0, 2'b00);
    run_op(5'b00010, 0, 1'b1, 1'b0, 2'b00);
    run_op(5'b00011, 1, 1'b0, 1'b0, 2'b00);
    run_op(5'b00100, 2, 1'b0, 1'b0, 2'b00);
    run_op(5'b00101, 3, 1'b0, 1'b0, 2'b00);
    run_op(5'b00110, 5, 1'b0, 1'b0, 2'b00);
    run_op(5'b00111, 5, 1'b0, 1'b0, 2'b01);
    run_op(5'b01000, 5, 1'b0, 1'b0, 2'b10);
    run_op(5'b01001, 4, 1'b0, 1'b1, 2'b00);
    run_op(5'b01010, 4, 1'b0, 1'b0, 2'b00);
    test_reject(5'b01011);
    test_reject(5'b11111);
    run_op(5'b00011, 1, 1'b0, 1'b0, 2'b00);
    test_nop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule